// File: doc/BRIEF.md
# Narrow-Mode Program-Counter Capability Tracker

This block holds the address of the program-counter capability for a core that can run with a program counter narrower than its widest register width. The pc is kept in the wide form: whenever the core runs narrow, every write takes the low narrow bits and copies the top narrow bit into all upper bits. The core presents one step per retiring or redirecting event. A step is one of four kinds: a sequential instruction that advances the pc by its length, a jump or taken branch, a trap return, or a trap entry that loads the handler address.

In narrow mode with finite bounds, an instruction that runs across the half-range point or past the top of the narrow space faults at once with a length violation, and that violation reports the start of the instruction. An instruction that ends exactly on one of those points completes normally. It leaves the capability poisoned, so the next instruction attempted takes a tag violation unless an interrupt or a higher-priority synchronous exception outranks it. For every exception the block drives the address and tag that the trap logic should save. The decoder and the trap registers are outside this block.

Top module: `pcc_narrow_tracker`

## Requirements
- R1: After reset the held address equals RESET_PC, the poisoned flag is 0 and no exception is signalled.
- R2: A sequential step (op 0) of length 2 (len4_i=0) or 4 (len4_i=1) that takes no exception, in narrow mode, sets the held address to the 32-bit sum pc+length modulo 2^32, sign-extended from bit 31 to 64 bits.
- R3: A jump/branch (op 1), trap return (op 2) or trap entry (op 3) that takes effect loads target_i. In narrow mode this is bits 31:0 sign-extended; in wide mode it is all 64 bits.
- R4: In narrow mode with inf_bounds_i=0, a checked step (ops 0 to 2) whose bytes cross 2^31 or run past 2^32 reports cause 3 (length). The exception address is the instruction start, with the tag set.
- R5: With inf_bounds_i=1 the same crossing raises no exception, and a sequential step wraps as in R2.
- R6: A sequential step that ends exactly at 2^31 or at 2^32 with inf_bounds_i=0 completes with no exception and sets the poisoned flag.
- R7: While the poisoned flag is set, a checked step reports cause 4 (tag). The exception address is 0 or the sign-extended 2^31, and the exception tag is 0.
- R8: Cause priority, from highest to lowest, is 1 interrupt, 2 synchronous input, 4 tag, 3 length; 0 means none. A step that signals any exception leaves the held address and the poisoned flag unchanged.
- R9: A trap entry (op 3) is never checked and always clears the poisoned flag. A jump or trap return that completes also clears it.
- R10: In wide mode (narrow_i=0) no boundary check applies, and a sequential step adds the length modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| narrow_i | input | 1 | 1 when the core runs with the 32-bit pc |
| step_valid_i | input | 1 | A step is presented this cycle |
| op_i | input | 2 | Step kind: 0 sequential, 1 jump/branch, 2 trap return, 3 trap entry |
| len4_i | input | 1 | Instruction length: 1 means 4 bytes, 0 means 2 bytes |
| target_i | input | 64 | Destination for ops 1 to 3 |
| inf_bounds_i | input | 1 | The capability has infinite bounds |
| irq_i | input | 1 | An interrupt is taken on this step |
| sync_exc_i | input | 1 | A higher-priority synchronous exception on this step |
| pcc_addr_o | output | 64 | Held capability address |
| pcc_unrep_o | output | 1 | Poisoned (unrepresentable) flag |
| exc_valid_o | output | 1 | This step traps |
| exc_cause_o | output | 3 | Cause code per R8 |
| epcc_addr_o | output | 64 | Address to save for the trap |
| epcc_tag_o | output | 1 | Tag to save for the trap |

## Verification
The sweep places instructions of both lengths at every even offset within six bytes below and two bytes above each narrow boundary, for both sequential steps and jumps, with finite and with infinite bounds. A design that compared with >= where it needs > would fault an instruction that ends exactly on the boundary instead of poisoning the capability. A design that dropped the sign extension would hold 0x80000000 instead of the all-ones upper half. After each poisoning, the bench walks the interrupt, synchronous and tag cases. A wrong priority order, a pc that advances on an exception, or a tag left set on the saved capability each shows up as a mismatched cause or address.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [1:0] {
        OP_SEQ  = 2'd0,
        OP_JUMP = 2'd1,
        OP_TRET = 2'd2,
        OP_TRAP = 2'd3
    } pcc_op_e;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_IRQ  = 3'd1,
        CAUSE_SYNC = 3'd2,
        CAUSE_LEN  = 3'd3,
        CAUSE_TAG  = 3'd4
    } pcc_cause_e;

endpackage

// File: rtl/pcc_sext.sv
module pcc_sext #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] ext_o
);
    generate
        if (OUT_W > IN_W) begin : g_widen
            assign ext_o = {{(OUT_W-IN_W){val_i[IN_W-1]}}, val_i};
        end else begin : g_same
            assign ext_o = val_i[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pcc_boundary_chk.sv
module pcc_boundary_chk #(
    parameter int W = 32
) (
    input  logic [W-1:0] pc_i,
    input  logic         len4_i,
    output logic         cross_o,
    output logic         exact_o,
    output logic [W-1:0] next_o
);
    localparam logic [W:0] HALF = (W+1)'(1) << (W-1);
    localparam logic [W:0] TOP  = (W+1)'(1) << W;

    logic [W:0] len_w;
    logic [W:0] end_w;

    always_comb begin
        len_w   = {{(W-2){1'b0}}, len4_i, ~len4_i, 1'b0};
        end_w   = {1'b0, pc_i} + len_w;
        cross_o = (({1'b0, pc_i} < HALF) && (end_w > HALF)) || (end_w > TOP);
        exact_o = (end_w == HALF) || (end_w == TOP);
        next_o  = end_w[W-1:0];
    end
endmodule

// File: rtl/pcc_exc_arb.sv
module pcc_exc_arb (
    input  logic       en_i,
    input  logic       irq_i,
    input  logic       sync_i,
    input  logic       tag_i,
    input  logic       len_i,
    output logic [2:0] cause_o
);
    import pcc_pkg::*;

    always_comb begin
        cause_o = CAUSE_NONE;
        if (en_i) begin
            if (irq_i)       cause_o = CAUSE_IRQ;
            else if (sync_i) cause_o = CAUSE_SYNC;
            else if (tag_i)  cause_o = CAUSE_TAG;
            else if (len_i)  cause_o = CAUSE_LEN;
        end
    end
endmodule

// File: rtl/pcc_narrow_tracker.sv
module pcc_narrow_tracker #(
    parameter int                  XLEN_MAX    = 64,
    parameter int                  XLEN_NARROW = 32,
    parameter logic [XLEN_MAX-1:0] RESET_PC    = '0
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                narrow_i,
    input  logic                step_valid_i,
    input  logic [1:0]          op_i,
    input  logic                len4_i,
    input  logic [XLEN_MAX-1:0] target_i,
    input  logic                inf_bounds_i,
    input  logic                irq_i,
    input  logic                sync_exc_i,
    output logic [XLEN_MAX-1:0] pcc_addr_o,
    output logic                pcc_unrep_o,
    output logic                exc_valid_o,
    output logic [2:0]          exc_cause_o,
    output logic [XLEN_MAX-1:0] epcc_addr_o,
    output logic                epcc_tag_o
);
    import pcc_pkg::*;

    localparam int NW = XLEN_NARROW;

    typedef struct packed {
        logic [XLEN_MAX-1:0] pc;
        logic                unrep;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic [NW-1:0]       seq_lo;
    logic                cross_w, exact_w;
    logic [XLEN_MAX-1:0] seq_ext, tgt_ext, wide_seq, tgt_pick;
    logic                checked_w, len_fault, edge_hit;
    logic [2:0]          cause_w;

    pcc_boundary_chk #(.W(NW)) u_bnd (
        .pc_i    (st_q.pc[NW-1:0]),
        .len4_i  (len4_i),
        .cross_o (cross_w),
        .exact_o (exact_w),
        .next_o  (seq_lo)
    );

    pcc_sext #(.IN_W(NW), .OUT_W(XLEN_MAX)) u_sext_seq (
        .val_i (seq_lo),
        .ext_o (seq_ext)
    );

    pcc_sext #(.IN_W(NW), .OUT_W(XLEN_MAX)) u_sext_tgt (
        .val_i (target_i[NW-1:0]),
        .ext_o (tgt_ext)
    );

    always_comb begin
        checked_w = step_valid_i && (op_i != OP_TRAP);
        len_fault = narrow_i && cross_w && !inf_bounds_i;
        edge_hit  = narrow_i && exact_w && !inf_bounds_i;
        wide_seq  = st_q.pc + {{(XLEN_MAX-3){1'b0}}, len4_i, ~len4_i, 1'b0};
        tgt_pick  = narrow_i ? tgt_ext : target_i;
    end

    pcc_exc_arb u_arb (
        .en_i    (checked_w),
        .irq_i   (irq_i),
        .sync_i  (sync_exc_i),
        .tag_i   (st_q.unrep),
        .len_i   (len_fault),
        .cause_o (cause_w)
    );

    always_comb begin
        st_d = st_q;
        if (step_valid_i) begin
            if (op_i == OP_TRAP) begin
                st_d.pc    = tgt_pick;
                st_d.unrep = 1'b0;
            end else if (cause_w == CAUSE_NONE) begin
                if (op_i == OP_SEQ) begin
                    st_d.pc    = narrow_i ? seq_ext : wide_seq;
                    st_d.unrep = edge_hit;
                end else begin
                    st_d.pc    = tgt_pick;
                    st_d.unrep = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.pc    <= RESET_PC;
            st_q.unrep <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pcc_addr_o  = st_q.pc;
    assign pcc_unrep_o = st_q.unrep;
    assign exc_cause_o = cause_w;
    assign exc_valid_o = (cause_w != CAUSE_NONE);
    assign epcc_addr_o = st_q.pc;
    assign epcc_tag_o  = !st_q.unrep;

    assert_narrow_sext_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_valid_i && narrow_i && (exc_cause_o == CAUSE_NONE || op_i == OP_TRAP))
        |=> ((&pcc_addr_o[XLEN_MAX-1:NW-1]) || !(|pcc_addr_o[XLEN_MAX-1:NW-1])));

    assert_len_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_cause_o == CAUSE_LEN) |-> (epcc_addr_o == pcc_addr_o && epcc_tag_o));

    assert_poison_on_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pcc_unrep_o |-> (pcc_addr_o[NW-2:0] == '0));

    assert_hold_on_exc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_valid_i && exc_valid_o) |=> ($stable(pcc_addr_o) && $stable(pcc_unrep_o)));

    assert_irq_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_valid_i && irq_i && op_i != OP_TRAP) |-> (exc_cause_o == CAUSE_IRQ));

    assert_trap_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_valid_i && op_i == OP_TRAP) |=> !pcc_unrep_o);

endmodule

// File: tb/sim_pcc_narrow_tracker.sv
module sim_pcc_narrow_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow = 1'b1;
    logic        step_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        len4 = 1'b0;
    logic [63:0] target = '0;
    logic        inf_b = 1'b0;
    logic        irq = 1'b0;
    logic        sync_e = 1'b0;
    logic [63:0] pcc_addr, epcc_addr;
    logic        pcc_unrep, exc_valid, epcc_tag;
    logic [2:0]  cause;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pcc_narrow_tracker #(.XLEN_MAX(64), .XLEN_NARROW(32), .RESET_PC(64'h0000_0000_0000_0100)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .narrow_i(narrow), .step_valid_i(step_valid),
        .op_i(op), .len4_i(len4), .target_i(target), .inf_bounds_i(inf_b),
        .irq_i(irq), .sync_exc_i(sync_e), .pcc_addr_o(pcc_addr), .pcc_unrep_o(pcc_unrep),
        .exc_valid_o(exc_valid), .exc_cause_o(cause), .epcc_addr_o(epcc_addr), .epcc_tag_o(epcc_tag)
    );

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic l4, input logic [63:0] t,
                         input logic f, input logic ir, input logic sy);
        @(negedge clk);
        op = o; len4 = l4; target = t; inf_b = f; irq = ir; sync_e = sy;
        step_valid = 1'b1;
        #1;
    endtask

    task automatic retire;
        @(posedge clk);
        #1;
        step_valid = 1'b0; irq = 1'b0; sync_e = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 addr", pcc_addr, 64'h100);
        chk("R1 unrep", {63'd0, pcc_unrep}, 64'd0);
        chk("R1 exc", {63'd0, exc_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Near-boundary sweep in narrow mode
        for (int b = 0; b < 2; b++) begin
            for (int k = 0; k < 5; k++) begin
                for (int l = 0; l < 2; l++) begin
                    for (int f = 0; f < 2; f++) begin
                        for (int o = 0; o < 2; o++) begin
                            logic [31:0] s, base, dist_h;
                            logic [32:0] dist_t;
                            int          ln;
                            logic        cr, ex, poison;
                            logic [2:0]  ec;
                            logic [63:0] ep;
                            base = (b == 0) ? 32'h8000_0000 : 32'h0;
                            s    = base - 32'd6 + 32'(2 * k);
                            ln   = (l == 1) ? 4 : 2;
                            dist_h = 32'h8000_0000 - s;
                            dist_t = 33'h1_0000_0000 - {1'b0, s};
                            cr = ((s < 32'h8000_0000) && (32'(ln) > dist_h)) || (33'(ln) > dist_t);
                            ex = ((s < 32'h8000_0000) && (32'(ln) == dist_h)) || (33'(ln) == dist_t);

                            // R3/R9: trap entry loads sign-extended target, clears poison
                            apply(2'd3, 1'b0, {32'h5A5A_0000, s}, 1'b0, 1'b0, 1'b0);
                            retire();
                            chk("R3 trap addr", pcc_addr, sx(s));
                            chk("R9 unrep clr", {63'd0, pcc_unrep}, 64'd0);

                            apply(2'(o), l[0], 64'h0000_0000_0000_1000, f[0], 1'b0, 1'b0);
                            ec = (cr && f == 0) ? 3'd3 : 3'd0;
                            chk(f == 0 ? "R4 cause" : "R5 cause", {61'd0, cause}, {61'd0, ec});
                            if (ec == 3'd3) begin
                                chk("R4 epcc addr", epcc_addr, sx(s));
                                chk("R4 epcc tag", {63'd0, epcc_tag}, 64'd1);
                            end
                            retire();
                            if (ec == 3'd3) ep = sx(s);
                            else if (o == 1) ep = sx(32'h1000);
                            else ep = sx(s + 32'(ln));
                            chk(o == 1 ? "R3 jump addr" : "R2 seq addr", pcc_addr, ep);
                            poison = (o == 0) && ex && (f == 0);
                            chk("R6 unrep", {63'd0, pcc_unrep}, {63'd0, poison});

                            if (ec == 3'd3) begin
                                apply(2'(o), l[0], 64'h1000, 1'b0, 1'b0, 1'b1);
                                chk("R8 sync over len", {61'd0, cause}, 64'd2);
                                retire();
                                chk("R8 hold", pcc_addr, sx(s));
                            end

                            if (poison) begin
                                for (int c = 0; c < 4; c++) begin
                                    logic [2:0] want;
                                    want = (c == 0 || c == 1) ? 3'd1 : ((c == 2) ? 3'd2 : 3'd4);
                                    apply(2'(c % 3), 1'b1, 64'h2000, 1'b0, (c < 2), (c == 1 || c == 2));
                                    chk(want == 3'd4 ? "R7 cause" : "R8 prio", {61'd0, cause}, {61'd0, want});
                                    chk("R7 epcc addr", epcc_addr, sx(s + 32'(ln)));
                                    chk("R7 epcc tag", {63'd0, epcc_tag}, 64'd0);
                                    retire();
                                    chk("R8 addr held", pcc_addr, sx(s + 32'(ln)));
                                    chk("R8 unrep held", {63'd0, pcc_unrep}, 64'd1);
                                end
                            end
                        end
                    end
                end
            end
        end

        // R3: trap return in narrow mode sign-extends
        apply(2'd3, 1'b0, 64'h0000_0000_0000_4000, 1'b0, 1'b0, 1'b0);
        retire();
        apply(2'd2, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0, 1'b0);
        chk("R3 tret no exc", {61'd0, cause}, 64'd0);
        retire();
        chk("R3 tret addr", pcc_addr, 64'hFFFF_FFFF_9ABC_DEF0);

        // R10: wide mode, no boundary checks
        narrow = 1'b0;
        apply(2'd3, 1'b0, 64'h0000_0000_7FFF_FFFE, 1'b0, 1'b0, 1'b0);
        retire();
        chk("R10 trap wide", pcc_addr, 64'h0000_0000_7FFF_FFFE);
        apply(2'd0, 1'b1, 64'h0, 1'b0, 1'b0, 1'b0);
        chk("R10 no len fault", {61'd0, cause}, 64'd0);
        retire();
        chk("R10 seq wide", pcc_addr, 64'h0000_0000_8000_0002);
        chk("R10 no poison", {63'd0, pcc_unrep}, 64'd0);
        apply(2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b0, 1'b0);
        retire();
        apply(2'd0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0);
        retire();
        chk("R10 wrap 2^64", pcc_addr, 64'h0);
        apply(2'd1, 1'b0, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0, 1'b0);
        retire();
        chk("R3 jump wide", pcc_addr, 64'h1234_5678_9ABC_DEF0);

        summary();
    end

endmodule